// File: doc/BRIEF.md
# Dual-Modulus Prescaler (Divide by 32 or 33)

This block divides a fast input clock by 32 or by 33. A single select input picks the ratio: high gives 32, low gives 33. It sits in the feedback path of a frequency synthesizer ahead of the programmable and swallow counters. Those counters flip the select once per reference period to set the overall division ratio.

The structure follows a ripple prescaler, but every stage runs on the one input clock and advances under an enable. A two-or-three cell comes first. Its state machine has the states `CELL_FIRST`, `CELL_SECOND` and `CELL_EXTRA`. The transitions are:
- `CELL_FIRST` always goes to `CELL_SECOND`.
- `CELL_SECOND` goes back to `CELL_FIRST` when no swallow is requested, and to `CELL_EXTRA` when one is.
- `CELL_EXTRA` always goes to `CELL_FIRST`.

The cell gives one tick each time it completes. Four toggle stages count these ticks in a carry chain. Each stage flips when the tick reaches it and every earlier stage is high.

A mode gate has two states: `GATE_SAMPLE` and `GATE_HOLD`. It captures the select in `GATE_SAMPLE` on the first input cycle of a period, then moves to `GATE_HOLD`. It returns to `GATE_SAMPLE` when the period wraps. The gate forms the swallow request as the NOR of the captured select and the NAND of all toggle stages. So the cell divides by three once, in the last cell cycle of a period, and only when 33 was selected.

The block drives two outputs. `div_clk` is the last toggle stage. `period_end` is high for the last input cycle of each output period.

Top module: `dmp_prescaler`

## Requirements
- R1: With `ratio_sel` high on the first input cycle of a period, that period lasts 32 input cycles. The time between `period_end` pulses is then 32 cycles.
- R2: With `ratio_sel` low on the first input cycle of a period, that period lasts 33 input cycles.
- R3: `period_end` is high for exactly one input cycle per output period, and that cycle is the last cycle of the period.
- R4: `div_clk` is low for the first 16 input cycles of every period. It is high for the remaining 16 cycles (ratio 32) or 17 cycles (ratio 33), so the swallowed cycle falls in the high half.
- R5: The select is sampled only on the first input cycle of a period. A change of `ratio_sel` on any later cycle of that period, including its last cycle, does not change that period's length.
- R6: While `rst_n` is low (asynchronous, active low), `div_clk` and `period_end` are 0. The first input cycle after release is cycle 1 of a fresh period, and that first period already has the selected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 1 | Ratio select: 1 divides by 32, 0 divides by 33 |
| div_clk | output | 1 | Divided clock, the last toggle stage |
| period_end | output | 1 | High on the last input cycle of each output period |

## Verification
Several select patterns are applied:
- Runs of a constant select confirm that each ratio repeats steadily.
- Alternating the select every period shows that the swallow is armed and disarmed cleanly between neighbouring periods.
- Flipping the select right after the sampling cycle, in the middle of a period, and on its very last cycle separates a design that samples at the boundary from one that reacts to the live input.
- A reset in the middle of a period, followed by a divide-by-33 period, shows whether the first period after release already carries the swallowed cycle.

The high and low split of `div_clk` in every period shows where the extra cycle lands.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    // Phases of the two-or-three input cell
    typedef enum logic [1:0] {
        CELL_FIRST  = 2'd0,
        CELL_SECOND = 2'd1,
        CELL_EXTRA  = 2'd2
    } cell_state_e;

    // Phases of the ratio-select sampling gate
    typedef enum logic {
        GATE_SAMPLE = 1'b0,
        GATE_HOLD   = 1'b1
    } gate_state_e;

endpackage

// File: rtl/dmp_cell23.sv
module dmp_cell23 (
    input  logic clk,
    input  logic rst_n,
    input  logic swallow_req,
    output logic tick
);
    import dmp_pkg::*;

    cell_state_e state_q;
    cell_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_FIRST:  state_d = CELL_SECOND;
            CELL_SECOND: state_d = swallow_req ? CELL_EXTRA : CELL_FIRST;
            CELL_EXTRA:  state_d = CELL_FIRST;
            default:     state_d = CELL_FIRST;
        endcase
    end

    // Output: the cell completes on its last input cycle
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            CELL_FIRST:  tick = 1'b0;
            CELL_SECOND: tick = !swallow_req;
            CELL_EXTRA:  tick = 1'b1;
            default:     tick = 1'b0;
        endcase
    end

    // The third phase is only reached on a swallow request
    AST_EXTRA_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_EXTRA) |-> $past(swallow_req)) else $error("extra phase without request"); // R2

    // A cell never completes on two adjacent input cycles
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("adjacent ticks"); // R1

endmodule

// File: rtl/dmp_toggle.sv
module dmp_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            q <= !q;
        end
    end

    AST_TOGGLE_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q != $past(q))) else $error("stage did not toggle"); // R4

    AST_HOLD_OFF_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)) else $error("stage moved without enable"); // R4

endmodule

// File: rtl/dmp_mode_gate.sv
module dmp_mode_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in,
    input  logic all_ones,
    input  logic wrap,
    output logic mode_q,
    output logic swallow_req
);
    import dmp_pkg::*;

    gate_state_e gate_q;
    gate_state_e gate_d;

    // State register, plus the captured select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GATE_SAMPLE;
            mode_q <= 1'b1;
        end else begin
            gate_q <= gate_d;
            if (gate_q == GATE_SAMPLE) begin
                mode_q <= mode_in;
            end
        end
    end

    // Next-state logic
    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_SAMPLE: gate_d = GATE_HOLD;
            GATE_HOLD:   gate_d = wrap ? GATE_SAMPLE : GATE_HOLD;
            default:     gate_d = GATE_SAMPLE;
        endcase
    end

    // Output: NOR of the captured select with the NAND of the toggle stages
    always_comb begin
        swallow_req = ~(mode_q | ~all_ones);
    end

    AST_SELECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q == GATE_HOLD) |=> $stable(mode_q)) else $error("select changed mid-period"); // R5

    AST_NO_WRAP_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q == GATE_SAMPLE) |-> !wrap) else $error("wrap on sampling cycle"); // R3

endmodule

// File: rtl/dmp_prescaler.sv
module dmp_prescaler #(
    parameter int STAGES = 4
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic ratio_sel,
    output logic div_clk,
    output logic period_end
);

    localparam int RATIO_LO = 2 << STAGES;
    localparam int RATIO_HI = RATIO_LO + 1;
    localparam int CNT_W    = $clog2(RATIO_HI + 1);

    logic              cell_tick;
    logic              swallow_req;
    logic              mode_q;
    logic              all_ones;
    logic [STAGES-1:0] stage_q;
    logic [STAGES:0]   carry;

    dmp_cell23 u_cell (
        .clk         (clk_in),
        .rst_n       (rst_n),
        .swallow_req (swallow_req),
        .tick        (cell_tick)
    );

    assign carry[0] = cell_tick;

    // Toggle chain; each stage is enabled by the carry that reaches it
    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            dmp_toggle u_tff (
                .clk   (clk_in),
                .rst_n (rst_n),
                .en    (carry[k]),
                .q     (stage_q[k])
            );
            assign carry[k+1] = carry[k] & stage_q[k];
        end
    endgenerate

    assign all_ones = &stage_q;

    dmp_mode_gate u_gate (
        .clk         (clk_in),
        .rst_n       (rst_n),
        .mode_in     (ratio_sel),
        .all_ones    (all_ones),
        .wrap        (carry[STAGES]),
        .mode_q      (mode_q),
        .swallow_req (swallow_req)
    );

    // Outputs
    always_comb begin
        div_clk    = stage_q[STAGES-1];
        period_end = carry[STAGES];
    end

    // Independent period-length counter, used by the assertions below
    logic [CNT_W-1:0] len_cnt;
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            len_cnt <= CNT_W'(1);
        end else if (period_end) begin
            len_cnt <= CNT_W'(1);
        end else begin
            len_cnt <= len_cnt + CNT_W'(1);
        end
    end

    AST_PERIOD_LEN_LO: assert property (@(posedge clk_in) disable iff (!rst_n)
        (period_end && mode_q) |-> (len_cnt == CNT_W'(RATIO_LO))) else $error("short period wrong"); // R1

    AST_PERIOD_LEN_HI: assert property (@(posedge clk_in) disable iff (!rst_n)
        (period_end && !mode_q) |-> (len_cnt == CNT_W'(RATIO_HI))) else $error("long period wrong"); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        len_cnt <= CNT_W'(RATIO_HI)) else $error("period overran"); // R3

    AST_WRAP_CLEARS: assert property (@(posedge clk_in) disable iff (!rst_n)
        period_end |=> (stage_q == '0 && !div_clk)) else $error("no clean wrap"); // R4

    always_comb begin
        if (rst_n == 1'b0) begin
            AST_RESET_QUIET: assert (!div_clk && !period_end) else $error("outputs active in reset"); // R6
        end
    end

endmodule

// File: tb/dmp_prescaler_test.sv
`timescale 1ns/100ps
module dmp_prescaler_test;

    localparam int SHORT_LEN = 32;
    localparam int LONG_LEN  = 33;
    localparam int LOW_HALF  = 16;

    typedef struct {
        int    len;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ratio_sel = 1'b1;
    logic div_clk;
    logic period_end;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    dmp_prescaler uut (
        .clk_in     (clk),
        .rst_n      (rst_n),
        .ratio_sel  (ratio_sel),
        .div_clk    (div_clk),
        .period_end (period_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: entered at the start of cycle 1 of a period (1 ns after a rising edge)
    task automatic run_period(input bit m, input int flip_at, input string tag);
        exp_item_t it;
        int len;
        len = m ? SHORT_LEN : LONG_LEN;
        it.len = len;
        it.tag = (tag != "") ? tag : (m ? "R1" : "R2");
        exp_q.push_back(it);
        ratio_sel = m;
        for (int c = 1; c <= len; c++) begin
            if (c == flip_at) ratio_sel = ~m;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        exp_q.delete();
        repeat (3) begin
            @(negedge clk);
            chk(div_clk == 1'b0, "R6 div_clk in reset", int'(div_clk), 0);
            chk(period_end == 1'b0, "R6 period_end in reset", int'(period_end), 0);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Monitor: samples mid-cycle and scores each period against the queue
    int  cyc = 0;
    bit  shape_bad = 1'b0;
    bit  stuck_seen = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            shape_bad = 1'b0;
        end else begin
            cyc++;
            if (div_clk !== (cyc > LOW_HALF)) shape_bad = 1'b1;
            if (period_end === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected period_end", cyc, 0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    chk(cyc == it.len, {it.tag, " period length"}, cyc, it.len);
                    chk(!shape_bad, "R4 div_clk low/high split", int'(shape_bad), 0);
                end
                cyc = 0;
                shape_bad = 1'b0;
            end else if (cyc > LONG_LEN && !stuck_seen) begin
                stuck_seen = 1'b1;
                chk(1'b0, "R3 period_end missing", cyc, LONG_LEN);
            end
        end
    end

    initial begin
        apply_reset();
        // steady short, steady long
        run_period(1'b1, 0, "R6 first short");
        run_period(1'b1, 0, "");
        run_period(1'b1, 0, "");
        run_period(1'b0, 0, "");
        run_period(1'b0, 0, "");
        // alternating
        for (int i = 0; i < 6; i++) run_period(i[0], 0, "");
        // late select changes must not alter the running period
        run_period(1'b1, 2,  "R5 flip cycle 2");
        run_period(1'b0, 2,  "R5 flip cycle 2");
        run_period(1'b1, 17, "R5 flip mid");
        run_period(1'b0, 20, "R5 flip mid");
        run_period(1'b1, 32, "R5 flip last");
        run_period(1'b0, 33, "R5 flip last");
        run_period(1'b1, 0, "");
        // reset in the middle of a period, then a long first period
        ratio_sel = 1'b0;
        repeat (10) begin
            @(posedge clk);
            #1;
        end
        apply_reset();
        run_period(1'b0, 0, "R6 first long");
        run_period(1'b1, 0, "");
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 all periods seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule